// File: doc/BRIEF.md
# Multidrop Serial Port with Address Filtering

This block is a full-duplex asynchronous serial port for multidrop links. It sends and receives either 8-bit frames or 9-bit frames, where the ninth bit marks a frame as an address. A 16x oversampling tick from outside sets the bit rate. The transmitter serializes a byte written to it. The receiver finds start bits, takes a majority vote of three samples per bit, and checks the stop bit.

In the 9-bit modes the receiver can be armed to listen only for address frames. With the arm bit set, data frames are dropped. An address frame is kept only if it matches this node's own address under a per-bit mask, or matches the node's broadcast address. The broadcast address is the node address ORed with the mask. Accepted frames load the receive buffer and the ninth-bit flag and raise the receive flag. A stop bit that samples low raises a sticky framing-error flag, whether or not the frame is kept.

Software clears the transmit, receive and framing flags through one-cycle clear strobes. Mode code 00 (a shift-register mode) is not served: in that mode the port neither sends nor receives.

Top module: `mdrop_uart`

## Requirements
- R1: After reset, txd is 1 and ti, ri, rb8, frame_err and rx_data are all 0.
- R2: In mode 01 a write sends start 0, then the eight data bits LSB first, then stop 1. Each bit lasts 16 ticks, and txd rests at 1 when idle.
- R3: In modes 10 and 11 the bit after the eight data bits is the value of tb8, followed by stop 1.
- R4: ti is 0 during the bit before the stop bit and rises as the stop bit begins. It stays set until ti_clr.
- R5: A write made while a frame is still being sent is ignored: the frame in flight is not disturbed and no second frame follows.
- R6: In mode 01, a received frame loads rx_data (LSB first), writes the stop bit value into rb8 and sets ri, provided sm2 is 0 or the stop bit is 1.
- R7: In modes 10 and 11 with sm2 = 0, every frame is accepted and rb8 takes the received ninth bit.
- R8: In modes 10 and 11 with sm2 = 1, a frame whose ninth bit is 0 leaves ri at 0 and rx_data unchanged.
- R9: With sm2 = 1 and ninth bit 1, a byte is accepted when it equals node_addr in every bit where node_mask is 1. Bits where node_mask is 0 are ignored. For example, address C0 with mask FE accepts both C0 and C1.
- R10: With sm2 = 1 and ninth bit 1, a byte is also accepted when it has a 1 in every position where (node_addr | node_mask) has a 1.
- R11: Each bit is the majority of samples 7, 8 and 9 of its 16. A low pulse on rxd that reads high at mid start bit is dropped, and a glitch that hits one sample does not change the data.
- R12: A stop bit read as 0 sets frame_err. frame_err stays set through later good frames until frame_err_clr.
- R13: With mode 00 a write sends nothing and incoming frames are ignored.
- R14: With rx_en = 0 incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| mode | input | 2 | 00 unused, 01 8-bit, 10/11 9-bit |
| rx_en | input | 1 | Receiver enable |
| sm2 | input | 1 | Address-only listening (9-bit) / valid-stop check (8-bit) |
| tb8 | input | 1 | Ninth bit to transmit |
| node_addr | input | 8 | This node's address |
| node_mask | input | 8 | Address compare mask, 1 = compared |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_data | input | 8 | Byte to send |
| ti_clr | input | 1 | Clear ti |
| ri_clr | input | 1 | Clear ri |
| frame_err_clr | input | 1 | Clear frame_err |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| ti | output | 1 | Transmit flag |
| ri | output | 1 | Receive flag |
| rb8 | output | 1 | Received ninth bit, or stop bit in 8-bit mode |
| rx_data | output | 8 | Receive buffer |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The receive filter is driven with random bytes under random addresses and masks, biased so that about half the bytes match the masked address. This separates the own-address compare from the broadcast compare. Directed cases cover the exact address example, a pure broadcast byte, data frames while armed, and the same frames with arming off, which isolates the ninth-bit rule from the address rule. The transmitter is tried with random bytes in both frame lengths and with a second write during a frame. The receiver is given a short start pulse and a one-sample data glitch, which test the vote, and a low stop bit followed by a clean frame, which tests that the error flag stays set.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [1:0] {
    MD_SHIFT    = 2'b00,
    MD_BYTE     = 2'b01,
    MD_NINE_FIX = 2'b10,
    MD_NINE_VAR = 2'b11
  } mdu_mode_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_e;
endpackage

// File: rtl/mdu_tx.sv
module mdu_tx #(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          active,
  input  logic          nine,
  input  logic          tb8,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          ti_clr,
  output logic          txd,
  output logic          ti
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned SW = DW + 2;
  localparam int unsigned IW = $clog2(DW + 4);

  logic          busy_q, busy_d;
  logic          txd_q, txd_d;
  logic          ti_q, ti_d;
  logic [SW-1:0] sh_q, sh_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] stop_q, stop_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    txd_d  = txd_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    stop_d = stop_q;
    cnt_d  = cnt_q;
    ti_d   = ti_q & ~ti_clr;
    if (!busy_q) begin
      if (wr && active) begin
        busy_d = 1'b1;
        txd_d  = 1'b0;
        sh_d   = {1'b1, (nine ? tb8 : 1'b1), wdata};
        stop_d = nine ? IW'(DW + 2) : IW'(DW + 1);
        idx_d  = '0;
        cnt_d  = '0;
      end
    end else if (tick) begin
      if (cnt_q == CW'(OVS - 1)) begin
        cnt_d = '0;
        if (idx_q == stop_q) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + IW'(1);
          txd_d = sh_q[0];
          sh_d  = {1'b1, sh_q[SW-1:1]};
          if (idx_q + IW'(1) == stop_q) ti_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      ti_q   <= 1'b0;
      sh_q   <= '1;
      idx_q  <= '0;
      stop_q <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      txd_q  <= txd_d;
      ti_q   <= ti_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      stop_q <= stop_d;
      cnt_q  <= cnt_d;
    end
  end

  assign txd = txd_q;
  assign ti  = ti_q;

  assert_idle_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_q);
  assert_ti_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti_q) |-> (busy_q && txd_q && idx_q == stop_q));
  assert_busy_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr && !tick) |=> ($stable(idx_q) && $stable(sh_q)));
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
  import mdu_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          enable,
  input  logic          nine,
  input  logic          sm2,
  input  logic          rxd,
  input  logic          addr_ok,
  input  logic          ri_clr,
  input  logic          fe_clr,
  output logic [DW-1:0] cand,
  output logic [DW-1:0] rx_data,
  output logic          rb8,
  output logic          ri,
  output logic          fe
);
  localparam int unsigned CW    = $clog2(OVS);
  localparam int unsigned IW    = $clog2(DW + 4);
  localparam int unsigned P_MID = OVS / 2;

  rx_state_e     st_q, st_d;
  logic          s1_q, s2_q, s3_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] stop_q, stop_d;
  logic          v7_q, v7_d, v8_q, v8_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          nb_q, nb_d;
  logic [DW-1:0] data_q, data_d;
  logic          rb8_q, rb8_d, ri_q, ri_d, fe_q, fe_d;
  logic          vote, nb_f, keep;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    stop_d = stop_q;
    v7_d   = v7_q;
    v8_d   = v8_q;
    sh_d   = sh_q;
    nb_d   = nb_q;
    data_d = data_q;
    rb8_d  = rb8_q;
    ri_d   = ri_q & ~ri_clr;
    fe_d   = fe_q & ~fe_clr;
    vote   = (v7_q & v8_q) | (v7_q & s2_q) | (v8_q & s2_q);
    nb_f   = (stop_q == IW'(DW + 2)) ? nb_q : vote;
    keep   = !sm2 || (nb_f && ((stop_q == IW'(DW + 1)) || addr_ok));
    unique case (st_q)
      RX_IDLE: begin
        if (enable && s3_q && !s2_q) begin
          st_d   = RX_RUN;
          cnt_d  = '0;
          idx_d  = '0;
          stop_d = nine ? IW'(DW + 2) : IW'(DW + 1);
        end
      end
      RX_RUN: begin
        if (!enable) begin
          st_d = RX_IDLE;
        end else if (tick) begin
          if (cnt_q == CW'(OVS - 1)) begin
            cnt_d = '0;
            idx_d = idx_q + IW'(1);
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
          if (cnt_q == CW'(P_MID - 1)) v7_d = s2_q;
          if (cnt_q == CW'(P_MID))     v8_d = s2_q;
          if (cnt_q == CW'(P_MID + 1)) begin
            if (idx_q == '0) begin
              if (vote) st_d = RX_IDLE;
            end else if (idx_q <= IW'(DW)) begin
              sh_d = {vote, sh_q[DW-1:1]};
            end else if (idx_q != stop_q) begin
              nb_d = vote;
            end else begin
              st_d = RX_IDLE;
              if (!vote) fe_d = 1'b1;
              if (keep) begin
                data_d = sh_q;
                rb8_d  = nb_f;
                ri_d   = 1'b1;
              end
            end
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      s3_q   <= 1'b1;
      cnt_q  <= '0;
      idx_q  <= '0;
      stop_q <= '0;
      v7_q   <= 1'b1;
      v8_q   <= 1'b1;
      sh_q   <= '0;
      nb_q   <= 1'b0;
      data_q <= '0;
      rb8_q  <= 1'b0;
      ri_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      s1_q   <= rxd;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      stop_q <= stop_d;
      v7_q   <= v7_d;
      v8_q   <= v8_d;
      sh_q   <= sh_d;
      nb_q   <= nb_d;
      data_q <= data_d;
      rb8_q  <= rb8_d;
      ri_q   <= ri_d;
      fe_q   <= fe_d;
    end
  end

  assign cand    = sh_q;
  assign rx_data = data_q;
  assign rb8     = rb8_q;
  assign ri      = ri_q;
  assign fe      = fe_q;

  assert_ri_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_q) |-> (!$past(sm2) || rb8_q));
  assert_data_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> ri_q);
  assert_fe_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_q && !fe_clr) |=> fe_q);
  assert_off_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st_q == RX_IDLE));
endmodule

// File: rtl/mdu_addr_filter.sv
module mdu_addr_filter #(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] cand,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] mask,
  output logic          hit
);
  logic [DW-1:0] bcast;
  logic          own_hit, bc_hit;

  always_comb begin
    bcast   = addr | mask;
    own_hit = ((cand ^ addr) & mask) == '0;
    bc_hit  = (cand & bcast) == bcast;
    hit     = own_hit | bc_hit;
  end
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
  import mdu_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic [1:0]    mode,
  input  logic          rx_en,
  input  logic          sm2,
  input  logic          tb8,
  input  logic [DW-1:0] node_addr,
  input  logic [DW-1:0] node_mask,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_data,
  input  logic          ti_clr,
  input  logic          ri_clr,
  input  logic          frame_err_clr,
  input  logic          rxd,
  output logic          txd,
  output logic          ti,
  output logic          ri,
  output logic          rb8,
  output logic [DW-1:0] rx_data,
  output logic          frame_err
);
  mdu_mode_e     md;
  logic          active, nine, hit;
  logic [DW-1:0] cand;

  assign md     = mdu_mode_e'(mode);
  assign active = (md != MD_SHIFT);
  assign nine   = (md == MD_NINE_FIX) || (md == MD_NINE_VAR);

  mdu_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .active(active), .nine(nine),
    .tb8(tb8), .wr(tx_wr), .wdata(tx_data), .ti_clr(ti_clr),
    .txd(txd), .ti(ti)
  );

  mdu_addr_filter #(.DW(DW)) u_filt (
    .cand(cand), .addr(node_addr), .mask(node_mask), .hit(hit)
  );

  mdu_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .enable(rx_en && active),
    .nine(nine), .sm2(sm2), .rxd(rxd), .addr_ok(hit), .ri_clr(ri_clr),
    .fe_clr(frame_err_clr), .cand(cand), .rx_data(rx_data), .rb8(rb8),
    .ri(ri), .fe(frame_err)
  );
endmodule

// File: tb/mdrop_uart_tb.sv
module mdrop_uart_tb;
  localparam int BP = 64;

  logic clk = 1'b0;
  logic rst_n, tick16, rx_en, sm2, tb8, tx_wr, ti_clr, ri_clr, fe_clr, rxd;
  logic [1:0] mode;
  logic [7:0] node_addr, node_mask, tx_data;
  logic txd, ti, ri, rb8, frame_err;
  logic [7:0] rx_data;
  int errors = 0, checks = 0;
  bit done = 0;
  int unsigned tdiv = 0;

  always #4 clk = ~clk;

  mdrop_uart u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .mode(mode), .rx_en(rx_en),
    .sm2(sm2), .tb8(tb8), .node_addr(node_addr), .node_mask(node_mask),
    .tx_wr(tx_wr), .tx_data(tx_data), .ti_clr(ti_clr), .ri_clr(ri_clr),
    .frame_err_clr(fe_clr), .rxd(rxd), .txd(txd), .ti(ti), .ri(ri),
    .rb8(rb8), .rx_data(rx_data), .frame_err(frame_err)
  );

  initial begin
    tick16 = 1'b0;
    forever begin
      @(negedge clk);
      tdiv++;
      tick16 = (tdiv % 4 == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    ti_clr = 1; ri_clr = 1; fe_clr = 1;
    clks(1);
    ti_clr = 0; ri_clr = 0; fe_clr = 0;
    clks(1);
  endtask

  task automatic write_tx(input logic [7:0] b);
    tx_data = b; tx_wr = 1;
    clks(1);
    tx_wr = 0;
  endtask

  task automatic tx_capture(input bit nine, output logic [7:0] b, output logic nb,
                            output logic st, output logic sp, output logic ti_pre,
                            output logic ti_stop);
    int w;
    w = 0;
    while (txd !== 1'b0 && w < 4000) begin clks(1); w++; end
    clks(BP / 2);
    st = txd;
    nb = 1'b1;
    for (int i = 0; i < 8; i++) begin
      clks(BP);
      b[i] = txd;
      if (!nine && i == 7) ti_pre = ti;
    end
    if (nine) begin
      clks(BP);
      nb = txd;
      ti_pre = ti;
    end
    clks(BP);
    sp = txd;
    ti_stop = ti;
  endtask

  task automatic rx_frame(input logic [7:0] b, input logic nb, input bit nine,
                          input logic sp, input int gbit);
    rxd = 0;
    clks(BP);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      if (i == gbit) begin
        clks(30); rxd = ~b[i]; clks(4); rxd = b[i]; clks(30);
      end else clks(BP);
    end
    if (nine) begin rxd = nb; clks(BP); end
    rxd = sp;
    clks(BP);
    rxd = 1;
    clks(BP);
  endtask

  function automatic bit exp_hit(input logic [7:0] b, input logic [7:0] a, input logic [7:0] m);
    logic [7:0] bc;
    bc = a | m;
    return (((b ^ a) & m) == 8'h00) || ((b & bc) == bc);
  endfunction

  task automatic rx_expect(input logic [7:0] b, input logic nb, input bit nine,
                           input bit exp_keep, input string req);
    logic [7:0] old;
    pulse_clr();
    old = rx_data;
    rx_frame(b, nb, nine, 1'b1, -1);
    chk(ri == exp_keep, req, ri, exp_keep);
    chk(rx_data == (exp_keep ? b : old), req, rx_data, exp_keep ? b : old);
    if (exp_keep) chk(rb8 == (nine ? nb : 1'b1), req, rb8, nine ? nb : 1'b1);
  endtask

  initial begin
    logic [7:0] b, cb, a;
    logic nb, st, sp, tp, ts, e;
    int unsigned sd;
    sd = $urandom(32'd2024);
    rst_n = 0; mode = 2'b01; rx_en = 1; sm2 = 0; tb8 = 0; tx_wr = 0; tx_data = 0;
    ti_clr = 0; ri_clr = 0; fe_clr = 0; rxd = 1; node_addr = 0; node_mask = 0;
    clks(5);
    // R1 reset state
    chk(txd == 1 && ti == 0 && ri == 0, "R1 flags", {txd, ti, ri}, 3'b100);
    chk(rb8 == 0 && frame_err == 0 && rx_data == 0, "R1 rx", {rb8, frame_err, rx_data}, 0);
    rst_n = 1;
    clks(5);

    // R2 / R4: 8-bit transmit
    for (int k = 0; k < 3; k++) begin
      b = 8'($urandom);
      write_tx(b);
      tx_capture(0, cb, nb, st, sp, tp, ts);
      chk(st == 0 && sp == 1, "R2 start/stop", {st, sp}, 2'b01);
      chk(cb == b, "R2 data", cb, b);
      chk(tp == 0 && ts == 1, "R4 ti timing", {tp, ts}, 2'b01);
      clks(BP);
      pulse_clr();
      chk(ti == 0, "R4 ti clear", ti, 0);
    end

    // R3: 9-bit transmit
    mode = 2'b11;
    for (int k = 0; k < 3; k++) begin
      b = 8'($urandom);
      tb8 = 1'($urandom);
      write_tx(b);
      tx_capture(1, cb, nb, st, sp, tp, ts);
      chk(cb == b && sp == 1, "R3 data", cb, b);
      chk(nb == tb8, "R3 ninth", nb, tb8);
      chk(tp == 0 && ts == 1, "R4 ti 9-bit", {tp, ts}, 2'b01);
      clks(BP);
      pulse_clr();
    end

    // R5: write during frame ignored
    mode = 2'b01;
    b = 8'hA5;
    write_tx(b);
    fork
      tx_capture(0, cb, nb, st, sp, tp, ts);
      begin clks(100); write_tx(8'h3C); end
    join
    chk(cb == 8'hA5, "R5 first frame intact", cb, 8'hA5);
    e = 1;
    for (int i = 0; i < 2 * BP; i++) begin clks(1); if (txd != 1) e = 0; end
    chk(e == 1, "R5 no second frame", e, 1);
    pulse_clr();

    // R6: 8-bit receive
    for (int k = 0; k < 3; k++) rx_expect(8'($urandom), 1'b1, 0, 1, "R6 rx 8-bit");

    // R7: 9-bit receive, sm2 = 0
    mode = 2'b10;
    for (int k = 0; k < 3; k++) rx_expect(8'($urandom), 1'($urandom), 1, 1, "R7 rx sm2=0");

    // R8: armed, data frames dropped
    sm2 = 1; node_addr = 8'h00; node_mask = 8'h00;
    rx_expect(8'h5A, 1'b0, 1, 0, "R8 data dropped");
    rx_expect(8'hFF, 1'b0, 1, 0, "R8 data dropped 2");

    // R9: address example and random masked compare
    node_addr = 8'hC0; node_mask = 8'hFE;
    rx_expect(8'hC0, 1'b1, 1, 1, "R9 exact");
    rx_expect(8'hC1, 1'b1, 1, 1, "R9 masked bit");
    rx_expect(8'hC2, 1'b1, 1, 0, "R9 mismatch");
    for (int k = 0; k < 6; k++) begin
      a = 8'($urandom); node_addr = a; node_mask = 8'($urandom) | 8'h81;
      b = 8'($urandom);
      if (k % 2 == 0) b = (a & node_mask) | (b & ~node_mask);
      rx_expect(b, 1'b1, 1, exp_hit(b, a, node_mask), "R9 random");
    end

    // R10: broadcast
    node_addr = 8'h40; node_mask = 8'h0F;
    rx_expect(8'h5F, 1'b1, 1, 1, "R10 broadcast");
    rx_expect(8'hFF, 1'b1, 1, 1, "R10 broadcast all-ones");
    rx_expect(8'h57, 1'b1, 1, 0, "R10 mask bit missing");

    // R11: majority vote
    sm2 = 0; mode = 2'b01;
    pulse_clr();
    rxd = 0; clks(8); rxd = 1; clks(3 * BP);
    chk(ri == 0, "R11 short start dropped", ri, 0);
    pulse_clr();
    rx_frame(8'h96, 1'b1, 0, 1'b1, 3);
    chk(ri == 1 && rx_data == 8'h96, "R11 glitch vote", rx_data, 8'h96);

    // R12: framing error sticky
    pulse_clr();
    rx_frame(8'h11, 1'b1, 0, 1'b0, -1);
    chk(frame_err == 1, "R12 fe set", frame_err, 1);
    ri_clr = 1; clks(1); ri_clr = 0;
    rx_frame(8'h22, 1'b1, 0, 1'b1, -1);
    chk(frame_err == 1 && rx_data == 8'h22, "R12 fe sticky", frame_err, 1);
    fe_clr = 1; clks(1); fe_clr = 0; clks(1);
    chk(frame_err == 0, "R12 fe clear", frame_err, 0);

    // R13: mode 00
    mode = 2'b00;
    pulse_clr();
    write_tx(8'h00);
    e = 1;
    for (int i = 0; i < 2 * BP; i++) begin clks(1); if (txd != 1) e = 0; end
    chk(e == 1, "R13 no transmit", e, 1);
    rx_frame(8'h77, 1'b1, 0, 1'b1, -1);
    chk(ri == 0 && rx_data == 8'h22, "R13 no receive", rx_data, 8'h22);

    // R14: receiver disabled
    mode = 2'b01; rx_en = 0;
    rx_frame(8'h99, 1'b1, 0, 1'b1, -1);
    chk(ri == 0 && rx_data == 8'h22, "R14 rx off", rx_data, 8'h22);
    rx_en = 1;
    rx_expect(8'h66, 1'b1, 0, 1, "R14 rx back on");

    finish_run();
  end
endmodule